// File: doc/BRIEF.md
# Digital Slope-Adaptive Delta Codec Core

This block is a half-duplex delta-modulation engine with a continuously variable slope. It handles one bit per sample clock and keeps a signed 10-bit estimate of the signal, which is meant to drive an external converter. In encode mode the data bit is a 1-bit comparator result: 1 means the analog input is above the estimate. That bit is sent out as serial NRZ data. In decode mode the data bit is the received NRZ stream. Both modes update the estimate in the same way.

Every sample the estimate leaks toward zero by one sixteenth of its value, then moves up or down by the current step. The step is held in fixed point with 8 fractional bits. It grows when the last three data bits are identical, which is the slope-overload condition, and otherwise decays slowly toward 1 LSB. The leak and decay shifts set time constants in sample clocks, so they scale with the clock rate.

Three controls act on the block. A force-zero input clears the state and makes the output alternate. A quieting input replaces only the transmitted data. An AGC flag reports large signals. A three-quarter-scale limit saturates the estimate and freezes step adaptation.

Top module: `cvsd_core`

## Requirements
- R1: The data bit is `cmp_above` when `mode_dec` is 0 (encode) and `rx_bit` when `mode_dec` is 1 (decode).
- R2: On each rising edge, unless force-zero is active, the new estimate is `est - (est >>> 4) + s` when the data bit is 1, or `est - (est >>> 4) - s` when it is 0. Here `s` is the integer part of the step, which is the step register shifted right by 8.
- R3: The step register grows by `(16384 - step) >> 4` when the data bit equals both of the two previous data bits. Reset and force-zero set the history to 0,0.
- R4: When there is no run, the step register becomes `step - (step >> 8)`, with a floor of 256 (1 LSB). It never exceeds 16384 (64 LSB).
- R5: A computed estimate of +384 or more is stored as +384, and one of -384 or less is stored as -384. While the present estimate has magnitude 384 or more, the step register is held.
- R6: `agc_n` is 0 exactly when the estimate is ≥ +256 or ≤ -256, and 1 otherwise.
- R7: While `zero_force_n` is 0, each rising edge clears the estimate, sets the step to 256, clears the history and the last data bit, and `tx_bit` carries the quieting pattern.
- R8: While `quiet_n` is 0, `tx_bit` carries the quieting pattern and the estimate still follows the data bit.
- R9: `tx_bit` changes only on the falling edge. With no quieting active, it is the last data bit in encode mode and 0 in decode mode. The quieting pattern is a phase bit that is 0 at reset and toggles on every rising edge.
- R10: After reset the estimate is 0, `agc_n` is 1 and `tx_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one data bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_dec | input | 1 | 0 = encode, 1 = decode |
| cmp_above | input | 1 | Comparator result in encode mode |
| rx_bit | input | 1 | Received NRZ data in decode mode |
| zero_force_n | input | 1 | Active-low force-zero |
| quiet_n | input | 1 | Active-low transmit quieting override |
| tx_bit | output | 1 | Serial NRZ data, updated on the falling edge |
| est | output | 10 | Signed reconstructed-signal estimate |
| agc_n | output | 1 | Active-low half-scale level flag |

## Verification
The bench drives long runs of equal bits until the estimate hits the ±384 limit, then reverses direction. A design that fails to freeze the step there, or that saturates at the wrong value, shows up as a wrong estimate on the way back. Strict alternation after reset checks the 1 LSB floor: a design that lets the step decay below one step stops moving the estimate. Force-zero and quieting are mixed into random traffic in both modes. A design that lets quieting corrupt the estimate, or that fails to clear the run history on force-zero, diverges from the bench model within a few samples. Each sample also compares the AGC flag against its threshold for both polarities.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;
  typedef enum logic {
    MODE_ENC = 1'b0,
    MODE_DEC = 1'b1
  } mode_e;
endpackage

// File: rtl/cvsd_rst_sync.sv
module cvsd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/cvsd_step_adapt.sv
module cvsd_step_adapt #(
  parameter int STEP_MAX = 64,
  parameter int FRAC_W   = 8,
  parameter int GROW_SH  = 4,
  parameter int DECAY_SH = 8,
  localparam int STEP_IW = $clog2(STEP_MAX) + 1,
  localparam int SQ_W    = STEP_IW + FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               zero_req,
  input  logic               data_bit,
  input  logic               freeze,
  output logic [STEP_IW-1:0] step_int
);
  localparam logic [SQ_W-1:0] MIN_Q = SQ_W'(1) << FRAC_W;
  localparam logic [SQ_W-1:0] MAX_Q = SQ_W'(STEP_MAX) << FRAC_W;

  logic [SQ_W-1:0] step_q, step_nx, headroom, grown, decayed;
  logic [1:0]      hist_q, hist_nx;
  logic            run;

  always_comb begin
    run      = (data_bit == hist_q[0]) && (data_bit == hist_q[1]);
    headroom = MAX_Q - step_q;
    grown    = step_q + (headroom >> GROW_SH);
    decayed  = step_q - (step_q >> DECAY_SH);
    if (decayed < MIN_Q) decayed = MIN_Q;
    step_nx = step_q;
    hist_nx = hist_q;
    if (zero_req) begin
      step_nx = MIN_Q;
      hist_nx = 2'b00;
    end else begin
      hist_nx = {hist_q[0], data_bit};
      if (!freeze) step_nx = run ? grown : decayed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= MIN_Q;
      hist_q <= 2'b00;
    end else begin
      step_q <= step_nx;
      hist_q <= hist_nx;
    end
  end

  assign step_int = step_q[SQ_W-1:FRAC_W];

  // R4
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q >= MIN_Q) && (step_q <= MAX_Q));
  // R5
  step_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !zero_req) |=> $stable(step_q));
  // R7
  step_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> (step_q == MIN_Q));
endmodule

// File: rtl/cvsd_estimator.sv
module cvsd_estimator #(
  parameter int EST_W   = 10,
  parameter int STEP_IW = 7,
  parameter int LEAK_SH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    zero_req,
  input  logic                    data_bit,
  input  logic [STEP_IW-1:0]      step_int,
  output logic signed [EST_W-1:0] est,
  output logic                    clamped,
  output logic                    agc_n
);
  localparam int FS     = 1 << (EST_W - 1);
  localparam int HALF   = FS / 2;
  localparam int THREEQ = (3 * FS) / 4;
  localparam int CW     = EST_W + 2;

  localparam logic signed [EST_W-1:0] HI_E   = EST_W'(THREEQ);
  localparam logic signed [EST_W-1:0] LO_E   = -HI_E;
  localparam logic signed [EST_W-1:0] HALF_E = EST_W'(HALF);
  localparam logic signed [EST_W-1:0] NHLF_E = -HALF_E;
  localparam logic signed [CW-1:0]    HI_X   = CW'(THREEQ);
  localparam logic signed [CW-1:0]    LO_X   = -HI_X;

  logic signed [EST_W-1:0] est_q, est_nx;
  logic signed [CW-1:0]    est_x, leak_x, step_x, delta_x, cand;

  always_comb begin
    est_x   = CW'(est_q);
    leak_x  = est_x >>> LEAK_SH;
    step_x  = CW'(signed'({1'b0, step_int}));
    delta_x = data_bit ? step_x : -step_x;
    cand    = est_x - leak_x + delta_x;
    if (zero_req)          est_nx = '0;
    else if (cand >= HI_X) est_nx = HI_E;
    else if (cand <= LO_X) est_nx = LO_E;
    else                   est_nx = EST_W'(cand);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) est_q <= '0;
    else        est_q <= est_nx;
  end

  assign est     = est_q;
  assign clamped = (est_q >= HI_E) || (est_q <= LO_E);
  assign agc_n   = !((est_q >= HALF_E) || (est_q <= NHLF_E));

  // R5
  est_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (est_q <= HI_E) && (est_q >= LO_E));
  // R7
  est_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> (est_q == '0));
endmodule

// File: rtl/cvsd_serial_out.sv
module cvsd_serial_out (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_req,
  input  logic quiet_req,
  input  logic mode_dec,
  input  logic data_bit,
  output logic tx_bit
);
  logic phase_q, phase_nx, last_q, last_nx, tx_q, tx_nx;

  always_comb begin
    phase_nx = ~phase_q;
    last_nx  = zero_req ? 1'b0 : data_bit;
    if (zero_req || quiet_req) tx_nx = phase_q;
    else if (mode_dec)         tx_nx = 1'b0;
    else                       tx_nx = last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      phase_q <= phase_nx;
      last_q  <= last_nx;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_nx;
  end

  assign tx_bit = tx_q;

  // R9
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/cvsd_core.sv
module cvsd_core #(
  parameter int EST_W    = 10,
  parameter int STEP_MAX = 64,
  parameter int FRAC_W   = 8,
  parameter int GROW_SH  = 4,
  parameter int DECAY_SH = 8,
  parameter int LEAK_SH  = 4,
  parameter int SYNC_ST  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_dec,
  input  logic                    cmp_above,
  input  logic                    rx_bit,
  input  logic                    zero_force_n,
  input  logic                    quiet_n,
  output logic                    tx_bit,
  output logic signed [EST_W-1:0] est,
  output logic                    agc_n
);
  localparam int STEP_IW = $clog2(STEP_MAX) + 1;

  cvsd_pkg::mode_e mode;
  logic srst_n, data_bit, zero_req, quiet_req, clamped;
  logic [STEP_IW-1:0] step_int;

  assign mode      = cvsd_pkg::mode_e'(mode_dec);
  assign data_bit  = (mode == cvsd_pkg::MODE_DEC) ? rx_bit : cmp_above;
  assign zero_req  = ~zero_force_n;
  assign quiet_req = ~quiet_n;

  cvsd_rst_sync #(.STAGES(SYNC_ST)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  cvsd_step_adapt #(
    .STEP_MAX(STEP_MAX), .FRAC_W(FRAC_W),
    .GROW_SH(GROW_SH), .DECAY_SH(DECAY_SH)
  ) i_step (
    .clk(clk), .rst_n(srst_n), .zero_req(zero_req),
    .data_bit(data_bit), .freeze(clamped), .step_int(step_int));

  cvsd_estimator #(
    .EST_W(EST_W), .STEP_IW(STEP_IW), .LEAK_SH(LEAK_SH)
  ) i_est (
    .clk(clk), .rst_n(srst_n), .zero_req(zero_req),
    .data_bit(data_bit), .step_int(step_int),
    .est(est), .clamped(clamped), .agc_n(agc_n));

  cvsd_serial_out i_ser (
    .clk(clk), .rst_n(srst_n), .zero_req(zero_req),
    .quiet_req(quiet_req), .mode_dec(mode_dec),
    .data_bit(data_bit), .tx_bit(tx_bit));
endmodule

// File: tb/test_cvsd_core.sv
`timescale 1ns/1ps
module test_cvsd_core;
  logic clk = 1'b0;
  logic rst_n, mode_dec, cmp_above, rx_bit, zero_force_n, quiet_n;
  logic tx_bit, agc_n;
  logic signed [9:0] est;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model state
  int est_m = 0, sq_m = 256;
  bit h0 = 0, h1 = 0, last_m = 0, phase_m = 0;
  bit prev_b = 0;

  always #2.5 clk = ~clk;

  cvsd_core i_cvsd_core (
    .clk(clk), .rst_n(rst_n), .mode_dec(mode_dec), .cmp_above(cmp_above),
    .rx_bit(rx_bit), .zero_force_n(zero_force_n), .quiet_n(quiet_n),
    .tx_bit(tx_bit), .est(est), .agc_n(agc_n));

  task automatic chk(input string tag, input string what, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
    end
  endtask

  function automatic int sat(input int v);
    if (v >= 384) return 384;
    if (v <= -384) return -384;
    return v;
  endfunction

  task automatic cyc(input bit md, input bit cv, input bit rv, input bit fzn,
                     input bit qn, input string tag);
    bit d, run, clp;
    int su, cand, exp_tx;
    mode_dec = md; cmp_above = cv; rx_bit = rv; zero_force_n = fzn; quiet_n = qn;
    @(posedge clk);
    d = md ? rv : cv;  // R1
    if (!fzn) begin
      est_m = 0; sq_m = 256; h0 = 0; h1 = 0; last_m = 0;
    end else begin
      run = (d == h0) && (d == h1);
      clp = (est_m >= 384) || (est_m <= -384);
      su = sq_m >>> 8;
      cand = est_m - (est_m >>> 4) + (d ? su : -su);
      if (!clp) begin
        if (run) sq_m = sq_m + ((16384 - sq_m) >>> 4);
        else begin
          sq_m = sq_m - (sq_m >>> 8);
          if (sq_m < 256) sq_m = 256;
        end
      end
      h1 = h0; h0 = d; last_m = d;
      est_m = sat(cand);
    end
    phase_m = ~phase_m;
    #1;
    chk(!fzn ? "R7" : tag, "est", int'(est), est_m);
    chk("R6", "agc_n", int'(agc_n), ((est_m >= 256) || (est_m <= -256)) ? 0 : 1);
    @(negedge clk);
    if (!fzn || !qn) exp_tx = phase_m;
    else exp_tx = md ? 0 : last_m;
    #1;
    chk(!fzn ? "R7" : (!qn ? "R8" : "R9"), "tx_bit", int'(tx_bit), exp_tx);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; mode_dec = 0; cmp_above = 0; rx_bit = 0;
    zero_force_n = 1; quiet_n = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "est", int'(est), 0);
    chk("R10", "agc_n", int'(agc_n), 1);
    chk("R10", "tx_bit", int'(tx_bit), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); #1;
    chk("R10", "tx_bit after release", int'(tx_bit), 0);

    // R4: strict alternation keeps the step on its 1 LSB floor
    for (int i = 0; i < 20; i++) cyc(0, i[0] ? 1'b0 : 1'b1, 0, 1, 1, "R4");
    // R3: run of ones grows the step
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, 1, 1, "R3");
    // R5: drive into positive clamp, then back out and into negative clamp
    for (int i = 0; i < 30; i++) cyc(0, 1, 0, 1, 1, "R5");
    chk("R5", "positive clamp value", int'(est), 384);
    for (int i = 0; i < 60; i++) cyc(0, 0, 0, 1, 1, "R5");
    chk("R5", "negative clamp value", int'(est), -384);
    // R7: force-zero mid-signal
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0, 1, "R7");
    // R1: decode follows rx_bit, comparator opposite
    for (int i = 0; i < 40; i++) begin
      bit b = (i % 5) < 3;
      cyc(1, ~b, b, 1, 1, "R1");
    end
    // R2 / R8: encode with quieting active, estimate still tracks
    for (int i = 0; i < 24; i++) cyc(0, (i % 6) < 4, 0, 1, 0, "R8");

    // randomized traffic with run-biased bits
    for (int i = 0; i < 4000; i++) begin
      bit b, md, fzn, qn;
      b = (($urandom % 4) == 0) ? ~prev_b : prev_b;
      prev_b = b;
      md = (($urandom % 8) < 3);
      fzn = (($urandom % 64) != 0);
      qn = (($urandom % 8) != 0);
      cyc(md, md ? 1'($urandom) : b, md ? b : 1'($urandom), fzn, qn, "R2");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule